// File: doc/BRIEF.md
# Range-Scaled Second-Order Pulse-Density Modulator

This block turns a held 16-bit output code into a single-bit pulse-density stream that drives a switched current source. Before the code reaches the modulator it is mapped onto one of four output spans, all referred to a common 24 mA full scale. Code 0 always lands on the bottom of the chosen span. That bottom is 0 mA for the zero-based spans and 4 mA for the live-zero span. The ones density of the stream is the requested level divided by full scale.

Software loads a code with a one-cycle strobe. The span select is decoded live on every cycle. A clear input overrides the held code at once and forces the bottom of the span. The override persists after clear is released and ends at the next load. The clear never alters the held code. Reset puts the modulator at rest at the bottom of the span.

Top module: `sdr_pdm_top`

## Requirements
- R1: On a clock edge with `rst_n` low, the first accumulator becomes 0 and the second becomes -1. The held code becomes 0 and the override is set. After reset, `bit_o` is 0, and the stream stays at the bottom of the selected span until a load is accepted.
- R2: The span select sets the modulator input x, in units of 2^-16 mA, with full scale FS = 24·65536. The encodings are: `2'b00` gives x = 20·code (0–5 V span), `2'b01` gives x = 4·65536 + 16·code, `2'b10` gives x = 20·code, and `2'b11` gives x = 24·code. The code used here is 0 while the override or `clr_i` is active.
- R3: Each clock computes q = (A2 ≥ 0), and `bit_o` shows q. The updates are A1' = sat25(A1 + x − q·FS), then A2' = sat30(A2 + A1' − q·FS). Here satN clamps to the signed N-bit range.
- R4: A code presented with `load_i` is captured on that edge. It changes x from the next cycle and first steers `bit_o` after the following edge.
- R5: While `clr_i` is high, the code used is 0 in the same cycle. The held code is not changed by the clear.
- R6: After `clr_i` falls, the bottom level stays in force until an edge with `load_i` high and `clr_i` low. A load taken while `clr_i` is high stores its code but does not lift the override.
- R7: From rest, or once settled, a zero x produces no ones at all.
- R8: Over a settled window of N cycles, the count of ones is within 10 of N·x/FS.
- R9: Within one span, larger codes never give a smaller ones density.
- R10: A change of span select takes effect without a new load.
- R11: No code and span combination reaches or wraps FS. Code 0xFFFF on span `2'b11` gives a density just below one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | One-cycle strobe that captures `code_i` |
| code_i | input | 16 | Output code, unsigned |
| range_i | input | 2 | Span select (see R2) |
| clr_i | input | 1 | Clear: forces the bottom of the span |
| bit_o | output | 1 | Pulse-density stream |

## Verification
Several properties are checked on every cycle:
- a load captures its code (R4);
- a clear leaves the held code untouched (R5);
- the override still holds the cycle after clear (R6);
- the scaled input stays below full scale (R11);
- a one always pulls the first accumulator down (R3);
- a zero input at rest stays silent (R7).

Ones density (R8), monotonic ordering across codes (R9), and the live-zero floor show up only over long windows. So do the sticky override seen at the output and the effect of a live span change. These are covered by the bench's scenarios. Its integer reference model compares `bit_o` on every clock.

// File: rtl/sdr_pkg.sv
// Shared span encoding and scaling constants for the pulse-density modulator.
// Assumes all spans are expressed in whole milliamps over a 24 mA full scale.
package sdr_pkg;

    localparam int unsigned FULL_MA = 24;

    typedef enum logic [1:0] {
        RNG_V5    = 2'b00,
        RNG_LIVE4 = 2'b01,
        RNG_I20   = 2'b10,
        RNG_I24   = 2'b11
    } range_e;

    // Span width in mA for a select value.
    function automatic logic [4:0] span_ma(input logic [1:0] sel);
        case (range_e'(sel))
            RNG_LIVE4: return 5'd16;
            RNG_I24:   return 5'd24;
            default:   return 5'd20;
        endcase
    endfunction

    // Floor of the span in mA for a select value.
    function automatic logic [4:0] floor_ma(input logic [1:0] sel);
        if (range_e'(sel) == RNG_LIVE4) return 5'd4;
        return 5'd0;
    endfunction

endpackage

// File: rtl/sdr_code_hold.sv
// Held output code with clear override.
// Stores the code on a load strobe. Produces the code the scaler should use.
// clr_i acts combinationally and sets a sticky override that only a load taken
// with clear low removes. Clear never writes the held code.
module sdr_code_hold #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              clr_i,
    output logic [CODE_W-1:0] eff_o
);

    logic [CODE_W-1:0] code_q;
    logic              ovr_q;

    // Capture the code on each load; reset returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= '0;
        else if (load_i) code_q <= code_i;
    end

    // Sticky override: set by reset or clear, lifted by a load with clear low.
    always_ff @(posedge clk) begin
        if (!rst_n)      ovr_q <= 1'b1;
        else if (clr_i)  ovr_q <= 1'b1;
        else if (load_i) ovr_q <= 1'b0;
    end

    // Code seen by the scaler: bottom of span while clear or override is active.
    always_comb begin
        eff_o = code_q;
        if (clr_i || ovr_q) eff_o = '0;
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> code_q == $past(code_i));                        // R4
    AST_CLEAR_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !load_i) |=> $stable(code_q));                    // R5
    AST_OVERRIDE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> eff_o == '0);                              // R6

endmodule

// File: rtl/sdr_span_scale.sv
// Maps the code onto the selected span in 2^-CODE_W mA units.
// Assumes X_W leaves room for the 24 mA full scale. The span select is decoded live.
module sdr_span_scale #(
    parameter int CODE_W = 16,
    parameter int X_W    = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] eff_i,
    input  logic [1:0]        range_i,
    output logic [X_W-1:0]    x_o
);
    import sdr_pkg::*;

    localparam logic [X_W-1:0] FS_X = X_W'(FULL_MA) << CODE_W;

    logic [X_W-1:0] base_w;
    logic [X_W-1:0] prod_w;

    // Floor plus code times span width, with no truncation inside X_W.
    always_comb begin
        base_w = X_W'(floor_ma(range_i)) << CODE_W;
        prod_w = X_W'(eff_i) * X_W'(span_ma(range_i));
        x_o    = base_w + prod_w;
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        x_o < FS_X);                                                // R11

endmodule

// File: rtl/sdr_integ.sv
// Saturating accumulator stage of the modulator.
// The next value is acc + add - (fb ? FB : 0), clamped to the signed W-bit range.
// Assumes FB fits in the internal sum width.
module sdr_integ #(
    parameter int                    W       = 25,
    parameter int                    IN_W    = 22,
    parameter int                    FB      = 1,
    parameter logic signed [W-1:0]   RST_VAL = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [IN_W-1:0] add_i,
    input  logic                   fb_i,
    output logic signed [W-1:0]    acc_o,
    output logic signed [W-1:0]    nxt_o
);

    localparam int SW = ((W > IN_W) ? W : IN_W) + 2;
    localparam logic signed [SW-1:0] MAX_V = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] MIN_V = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};
    localparam logic signed [SW-1:0] FB_S  = SW'(FB);

    logic signed [W-1:0]  acc_q;
    logic signed [SW-1:0] sum_w;

    // Wide sum with feedback, then clamp to the stage width.
    always_comb begin
        sum_w = SW'(acc_q) + SW'(add_i);
        if (fb_i) sum_w = sum_w - FB_S;
        if (sum_w > MAX_V)      nxt_o = MAX_V[W-1:0];
        else if (sum_w < MIN_V) nxt_o = MIN_V[W-1:0];
        else                    nxt_o = sum_w[W-1:0];
    end

    // State register with parameterised reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= RST_VAL;
        else        acc_q <= nxt_o;
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/sdr_mod2.sv
// Second-order single-bit modulator with a unipolar input x in [0, FS).
// A one is emitted when the second accumulator is non-negative. The feedback of
// FS is applied to both stages, and the second stage takes the updated first stage.
module sdr_mod2 #(
    parameter int X_W  = 21,
    parameter int I1_W = 25,
    parameter int I2_W = 30,
    parameter int FS   = 1572864
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [X_W-1:0] x_i,
    output logic           bit_o
);

    logic signed [X_W:0]    x_s;
    logic signed [I1_W-1:0] a1_q;
    logic signed [I1_W-1:0] a1_n;
    logic signed [I2_W-1:0] a2_q;
    logic signed [I2_W-1:0] a2_n;
    logic                   q_w;

    // Zero-extend the input into a signed operand.
    assign x_s = signed'({1'b0, x_i});
    // Quantizer: sign of the second accumulator.
    assign q_w   = ~a2_q[I2_W-1];
    assign bit_o = q_w;

    sdr_integ #(.W(I1_W), .IN_W(X_W+1), .FB(FS), .RST_VAL('0)) u_stage1 (
        .clk(clk), .rst_n(rst_n), .add_i(x_s), .fb_i(q_w),
        .acc_o(a1_q), .nxt_o(a1_n)
    );

    sdr_integ #(.W(I2_W), .IN_W(I1_W), .FB(FS), .RST_VAL('1)) u_stage2 (
        .clk(clk), .rst_n(rst_n), .add_i(a1_n), .fb_i(q_w),
        .acc_o(a2_q), .nxt_o(a2_n)
    );

    AST_FB_PULLS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o |=> a1_q <= $past(a1_q));                              // R3
    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (x_i == '0 && a1_q <= 0 && a2_q < 0) |=> !bit_o);            // R7

endmodule

// File: rtl/sdr_pdm_top.sv
// Range-scaled pulse-density modulator top.
// Chains hold -> scale -> modulate. Assumes a single clock domain and synchronous
// active-low reset. Full scale is 24 mA in units of 2^-CODE_W mA.
module sdr_pdm_top #(
    parameter int CODE_W = 16,
    parameter int I1_W   = 25,
    parameter int I2_W   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        range_i,
    input  logic              clr_i,
    output logic              bit_o
);
    import sdr_pkg::*;

    localparam int X_W = CODE_W + 5;
    localparam int FS  = int'(FULL_MA) << CODE_W;

    logic [CODE_W-1:0] eff_w;
    logic [X_W-1:0]    x_w;

    sdr_code_hold #(.CODE_W(CODE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .code_i(code_i),
        .clr_i(clr_i), .eff_o(eff_w)
    );

    sdr_span_scale #(.CODE_W(CODE_W), .X_W(X_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .eff_i(eff_w), .range_i(range_i), .x_o(x_w)
    );

    sdr_mod2 #(.X_W(X_W), .I1_W(I1_W), .I2_W(I2_W), .FS(FS)) u_mod (
        .clk(clk), .rst_n(rst_n), .x_i(x_w), .bit_o(bit_o)
    );

endmodule

// File: tb/sim_sdr_pdm_top.sv
`timescale 1ns/1ps
module sim_sdr_pdm_top;

    localparam longint FS  = 24 * 65536;
    localparam int     TOL = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        load_i = 0;
    logic [15:0] code_i = 0;
    logic [1:0]  range_i = 2'b01;
    logic        clr_i = 0;
    logic        bit_o;

    int n_chk = 0;
    int n_fail = 0;
    longint cyc = 0;

    sdr_pdm_top u0 (.clk(clk), .rst_n(rst_n), .load_i(load_i), .code_i(code_i),
                    .range_i(range_i), .clr_i(clr_i), .bit_o(bit_o));

    always #4 clk = ~clk;

    // Reference scaling from R2.
    function automatic longint xval(longint code, logic [1:0] r);
        case (r)
            2'b01:   return 4 * 65536 + 16 * code;
            2'b11:   return 24 * code;
            default: return 20 * code;
        endcase
    endfunction

    function automatic longint sat(longint v, int w);
        longint lim = longint'(1) <<< (w - 1);
        if (v > lim - 1) return lim - 1;
        if (v < -lim)    return -lim;
        return v;
    endfunction

    // Behavioural model (R1-R6, R10), updated at every rising edge.
    longint m_a1 = 0, m_a2 = -1, m_code = 0;
    bit     m_ovr = 1;
    always @(posedge clk) begin
        longint x, n1, n2;
        bit q;
        cyc++;
        if (!rst_n) begin
            m_a1 = 0; m_a2 = -1; m_code = 0; m_ovr = 1;
        end else begin
            x  = xval((m_ovr || clr_i) ? 0 : m_code, range_i);
            q  = (m_a2 >= 0);
            n1 = sat(m_a1 + x - (q ? FS : 0), 25);
            n2 = sat(m_a2 + n1 - (q ? FS : 0), 30);
            m_a1 = n1; m_a2 = n2;
            if (load_i) m_code = code_i;
            if (clr_i) m_ovr = 1; else if (load_i) m_ovr = 0;
        end
    end

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R3).
    always @(negedge clk) begin
        if (rst_n) chk(bit_o == (m_a2 >= 0), "R3 per-cycle", bit_o, m_a2 >= 0);
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic do_load(logic [15:0] c);
        @(negedge clk); load_i = 1; code_i = c;
        @(negedge clk); load_i = 0;
    endtask

    task automatic count_ones(int n, output int ones);
        ones = 0;
        repeat (n) begin
            @(negedge clk);
            ones += bit_o;
        end
    endtask

    task automatic dens(longint x, string req, output int ones);
        longint exp;
        repeat (256) @(negedge clk);
        count_ones(2048, ones);
        exp = (x * 2048 + FS / 2) / FS;
        chk((ones >= exp - TOL) && (ones <= exp + TOL), req, ones, exp);
    endtask

    initial begin
        int ones;
        int prev;
        logic [15:0] mono [4] = '{16'h1000, 16'h4000, 16'h9000, 16'hF000};

        // R1: reset state.
        range_i = 2'b10;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(bit_o == 0, "R1 reset bit", bit_o, 0);
        count_ones(300, ones);
        chk(ones == 0, "R1/R7 zero span silent from rest", ones, 0);

        // R1/R2/R10: live-zero floor with no load, span changed live.
        range_i = 2'b01;
        dens(xval(0, 2'b01), "R2/R10 live-zero floor", ones);

        // R7/R10: back to a zero-based span settles to silence.
        range_i = 2'b00;
        repeat (600) @(negedge clk);
        count_ones(512, ones);
        chk(ones == 0, "R7 settled zero silent", ones, 0);

        // R8: mid-scale on 0-20 mA span.
        range_i = 2'b10;
        do_load(16'h8000);
        dens(xval(16'h8000, 2'b10), "R8 mid-scale density", ones);

        // R9: monotonic across codes on 0-24 mA span.
        range_i = 2'b11;
        prev = -1;
        foreach (mono[k]) begin
            do_load(mono[k]);
            dens(xval(mono[k], 2'b11), "R8 span 11 density", ones);
            chk(ones >= prev, "R9 monotonic", ones, prev);
            prev = ones;
        end

        // R11: top code just below full scale.
        do_load(16'hFFFF);
        dens(xval(16'hFFFF, 2'b11), "R11 top code density", ones);
        chk(ones < 2048 + 1 && ones > 2030, "R11 below full scale", ones, 2048);

        // R5/R6: clear on live-zero span.
        range_i = 2'b01;
        do_load(16'hC000);
        @(negedge clk); clr_i = 1;
        dens(xval(0, 2'b01), "R5 clear forces floor", ones);
        do_load(16'h2000);
        dens(xval(0, 2'b01), "R6 load under clear keeps floor", ones);
        @(negedge clk); clr_i = 0;
        dens(xval(0, 2'b01), "R6 floor persists after release", ones);
        do_load(16'h2000);
        dens(xval(16'h2000, 2'b01), "R6 load lifts override", ones);

        // R4: load timing from rest.
        do_reset();
        range_i = 2'b10;
        @(negedge clk);
        load_i = 1; code_i = 16'hFFFF;
        @(negedge clk);
        load_i = 0;
        chk(bit_o == 0, "R4 no effect at capture edge", bit_o, 0);
        @(negedge clk);
        chk(bit_o == 1, "R4 effect after next edge", bit_o, 1);

        repeat (20) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule